// File: doc/BRIEF.md
# Halfword Lane-Swapping DMA Write Engine

This block moves a payload from a peripheral into memory for a device whose 16-bit data bus has its byte lanes crossed relative to memory. A request carries a start address, a byte count and a bypass flag. The payload then arrives one byte per handshake. The engine packs the bytes into a local chunk buffer and writes each full chunk to memory as one burst. A chunk holds at most `CHUNK_BYTES` bytes, which is 64 by default. Memory takes each burst through a valid/ready handshake. A base register supplies high address bits, and these are ORed into the address of every request.

In swap mode the engine forces the address and the length to even values. The two bytes of every halfword trade places, and any odd trailing byte is pulled from the stream and discarded, so the next request begins on a clean boundary. In bypass mode the bytes land in arrival order at the exact address and length given. Bypass mode uses the same chunking as swap mode.

The controller has five states:
- `ST_IDLE` waits for a request.
- `ST_FILL` accepts payload bytes into the chunk buffer.
- `ST_ISSUE` presents a full chunk to memory.
- `ST_DRAIN` swallows a dropped odd byte.
- `ST_FINISH` emits the one-cycle completion pulse.

The transitions are:
- IDLE→FILL on a request with a non-zero effective length.
- IDLE→DRAIN on a swap request of length one.
- IDLE→FINISH on a request whose effective length is zero and that has no odd byte.
- FILL→ISSUE when the last byte of the chunk is taken.
- ISSUE→FILL when a burst is accepted and more bytes remain.
- ISSUE→DRAIN when the final burst is accepted and an odd byte is pending.
- ISSUE→FINISH when the final burst is accepted and nothing is pending.
- DRAIN→FINISH when the odd byte is taken.
- FINISH→IDLE unconditionally.

Top module: `hsw_dma_wr`

## Requirements
- R1: The first burst address equals the request address ORed with the base register value. The base value is taken when the request is accepted.
- R2: In swap mode (`req_bypass`=0), bit 0 is cleared in both the effective address and the length before any burst is formed.
- R3: In swap mode with an odd length, the last payload byte is still accepted from the byte stream. It is never written, so the memory byte after the even part is left untouched.
- R4: In swap mode, payload byte number i of a chunk is written at byte offset i XOR 1 of that chunk. Offset p of `mem_data` occupies bits [8p+7:8p].
- R5: In bypass mode, byte i goes to address+i, with the address and the length exactly as requested, odd values included.
- R6: A payload longer than `CHUNK_BYTES` is written as successive bursts of `CHUNK_BYTES` bytes each, plus a final burst that carries the remainder. Each burst address is the previous address plus the previous burst length.
- R7: A burst is raised only once all of its bytes are buffered. While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_len` and `mem_data` hold steady.
- R8: `in_ready` is low whenever `mem_valid` is high, so no byte of the next chunk is taken before the current burst is accepted.
- R9: `done` is high for exactly one cycle once the final burst has been accepted, or once the odd byte that follows it has been consumed.
- R10: A request whose effective length is zero produces `done` and no burst.
- R11: Right after reset, `req_ready`=1, `in_ready`=0, `mem_valid`=0 and `done`=0, and the base register holds zero.
- R12: A pulse on `base_wr` loads `base_wdata` into the base register. The new value applies to the next request accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | ADDR_W | Base register write value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken |
| req_addr | input | ADDR_W | Request start address |
| req_len | input | LEN_W | Request byte count |
| req_bypass | input | 1 | 1: no swap, no alignment |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Payload byte taken |
| in_data | input | 8 | Payload byte |
| mem_valid | output | 1 | Burst present |
| mem_ready | input | 1 | Memory accepts burst |
| mem_addr | output | ADDR_W | Burst start address |
| mem_len | output | $clog2(CHUNK_BYTES)+1 | Burst byte count |
| mem_data | output | CHUNK_BYTES*8 | Burst bytes, offset p at [8p+7:8p] |
| done | output | 1 | One-cycle completion pulse |

## Verification
Faults in the fill counter or in the chunk length show up at the ports on the very next burst. That burst either leaves too early, carrying bytes a chunk has not yet received, or leaves late and swallows bytes that belong to the following chunk. The stream would then stall or overrun, and both effects are visible within one chunk time. A wrong remaining-length or address register appears as a wrong address on the second burst of a long transfer, or as a missing or extra burst. A forgotten odd-byte drain shifts every byte of the following request by one position, so that request is run straight after the odd one.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } hsw_state_e;
endpackage

// File: rtl/hsw_addr_gen.sv
module hsw_addr_gen #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int CHUNK_BYTES = 64,
    localparam int CW         = $clog2(CHUNK_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CW-1:0]     chunk_len,
    output logic              last_chunk,
    output logic              zero_left
);
    logic [LEN_W-1:0] rem_len;

    always_comb begin
        if (rem_len >= LEN_W'(CHUNK_BYTES)) begin
            chunk_len = CW'(CHUNK_BYTES);
        end else begin
            chunk_len = rem_len[CW-1:0];
        end
        last_chunk = (rem_len <= LEN_W'(CHUNK_BYTES));
        zero_left  = (rem_len == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem_len  <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            rem_len  <= load_len;
        end else if (advance) begin
            cur_addr <= cur_addr + ADDR_W'(chunk_len);
            rem_len  <= rem_len - LEN_W'(chunk_len);
        end
    end

    // R6
    rem_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> (rem_len < $past(rem_len)));
endmodule

// File: rtl/hsw_pack_buf.sv
module hsw_pack_buf #(
    parameter int CHUNK_BYTES = 64,
    localparam int IW         = $clog2(CHUNK_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic                     swap,
    input  logic [7:0]               wr_data,
    output logic [CHUNK_BYTES*8-1:0] flat
);
    logic [IW-1:0] dest;

    always_comb begin
        dest = swap ? (wr_idx ^ IW'(1)) : wr_idx;
    end

    for (genvar g = 0; g < CHUNK_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (wr_en && (dest == IW'(g))) begin
                lane_q <= wr_data;
            end
        end
        assign flat[g*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/hsw_ctl.sv
module hsw_ctl
    import hsw_pkg::*;
#(
    parameter int CHUNK_BYTES = 64,
    localparam int CW         = $clog2(CHUNK_BYTES) + 1,
    localparam int IW         = $clog2(CHUNK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          zero_len,
    input  logic          drop_odd,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [CW-1:0] chunk_len,
    input  logic          last_chunk,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic          done,
    output logic          load,
    output logic          buf_wr,
    output logic [IW-1:0] fill_idx,
    output logic          advance
);
    hsw_state_e state_q, state_d;
    logic       drop_q;
    logic       chunk_full;

    always_comb begin
        chunk_full = buf_wr && (fill_idx == IW'(chunk_len - CW'(1)));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!zero_len)     state_d = ST_FILL;
                    else if (drop_odd) state_d = ST_DRAIN;
                    else               state_d = ST_FINISH;
                end
            end
            ST_FILL: begin
                if (chunk_full) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (mem_ready) begin
                    if (!last_chunk) state_d = ST_FILL;
                    else if (drop_q) state_d = ST_DRAIN;
                    else             state_d = ST_FINISH;
                end
            end
            ST_DRAIN: begin
                if (in_valid) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        in_ready  = (state_q == ST_FILL) || (state_q == ST_DRAIN);
        mem_valid = (state_q == ST_ISSUE);
        done      = (state_q == ST_FINISH);
        load      = req_ready && req_valid;
        buf_wr    = (state_q == ST_FILL) && in_valid;
        advance   = mem_valid && mem_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_idx <= '0;
            drop_q   <= 1'b0;
        end else begin
            if (load) begin
                fill_idx <= '0;
                drop_q   <= drop_odd;
            end else if (advance) begin
                fill_idx <= '0;
            end else if (buf_wr) begin
                fill_idx <= fill_idx + IW'(1);
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    no_fill_in_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && in_ready));
    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && !(state_q == ST_DRAIN) |-> ({1'b0, fill_idx} < chunk_len));
    // R7
    issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid);
    // R9
    done_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && $past(mem_valid) |-> $past(mem_ready));
endmodule

// File: rtl/hsw_dma_wr.sv
module hsw_dma_wr #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int CHUNK_BYTES = 64,
    localparam int CW         = $clog2(CHUNK_BYTES) + 1,
    localparam int IW         = $clog2(CHUNK_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     base_wr,
    input  logic [ADDR_W-1:0]        base_wdata,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LEN_W-1:0]         req_len,
    input  logic                     req_bypass,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [7:0]               in_data,
    output logic                     mem_valid,
    input  logic                     mem_ready,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [CW-1:0]            mem_len,
    output logic [CHUNK_BYTES*8-1:0] mem_data,
    output logic                     done
);
    logic [ADDR_W-1:0] base_q;
    logic              bypass_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [LEN_W-1:0]  eff_len;
    logic              zero_len;
    logic              drop_odd;
    logic              load;
    logic              buf_wr;
    logic              advance;
    logic [IW-1:0]     fill_idx;
    logic [CW-1:0]     chunk_len;
    logic              last_chunk;
    logic              zero_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            bypass_q <= 1'b0;
        end else begin
            if (base_wr) base_q <= base_wdata;
            if (load)    bypass_q <= req_bypass;
        end
    end

    always_comb begin
        eff_addr = req_addr | base_q;
        eff_len  = req_len;
        drop_odd = 1'b0;
        if (!req_bypass) begin
            eff_addr[0] = 1'b0;
            eff_len[0]  = 1'b0;
            drop_odd    = req_len[0];
        end
        zero_len = (eff_len == '0);
    end

    hsw_ctl #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .zero_len   (zero_len),
        .drop_odd   (drop_odd),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .chunk_len  (chunk_len),
        .last_chunk (last_chunk),
        .mem_ready  (mem_ready),
        .mem_valid  (mem_valid),
        .done       (done),
        .load       (load),
        .buf_wr     (buf_wr),
        .fill_idx   (fill_idx),
        .advance    (advance)
    );

    hsw_addr_gen #(
        .ADDR_W      (ADDR_W),
        .LEN_W       (LEN_W),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_addr  (eff_addr),
        .load_len   (eff_len),
        .advance    (advance),
        .cur_addr   (mem_addr),
        .chunk_len  (chunk_len),
        .last_chunk (last_chunk),
        .zero_left  (zero_left)
    );

    hsw_pack_buf #(.CHUNK_BYTES(CHUNK_BYTES)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_idx  (fill_idx),
        .swap    (!bypass_q),
        .wr_data (in_data),
        .flat    (mem_data)
    );

    assign mem_len = chunk_len;

    // R2
    swap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !bypass_q |-> (!mem_addr[0] && !mem_len[0]));
    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> $stable(mem_addr) && $stable(mem_len) && $stable(mem_data));
    // R6
    burst_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_len != '0) && (mem_len <= CW'(CHUNK_BYTES)) && !zero_left);
endmodule

// File: tb/hsw_dma_wr_tb.sv
module hsw_dma_wr_tb;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int CB     = 64;
    localparam int CW     = $clog2(CB) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              base_wr = 1'b0;
    logic [ADDR_W-1:0] base_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_bypass = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_data = '0;
    logic              mem_valid;
    logic              mem_ready = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [CW-1:0]     mem_len;
    logic [CB*8-1:0]   mem_data;
    logic              done;

    int checks = 0;
    int errors = 0;
    logic [7:0]        img [0:4095];
    logic [ADDR_W-1:0] b_addr [0:15];
    int                b_len  [0:15];
    int                b_n = 0;
    int                done_n = 0;
    int                hold_err = 0;
    int                overlap_err = 0;
    bit                stall_en = 1'b0;
    int                stall_cnt = 0;
    logic              pend = 1'b0;
    logic [ADDR_W-1:0] pend_addr = '0;

    always #4 clk = ~clk;

    hsw_dma_wr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CB)) u_dut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_bypass(req_bypass), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_data(mem_data), .done(done)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (pend && !(mem_valid && mem_addr == pend_addr)) hold_err++;
            pend <= mem_valid && !mem_ready;
            pend_addr <= mem_addr;
            if (mem_valid && mem_ready) begin
                if (b_n < 16) begin
                    b_addr[b_n] = mem_addr;
                    b_len[b_n]  = int'(mem_len);
                end
                b_n++;
                for (int p = 0; p < int'(mem_len); p++)
                    img[(mem_addr + ADDR_W'(p)) & 32'hFFF] = mem_data[p*8 +: 8];
            end
            if (done) done_n++;
        end
    end

    always @(negedge clk) begin
        if (mem_valid && in_ready) overlap_err++;
        stall_cnt++;
        mem_ready <= stall_en ? (stall_cnt % 3 == 0) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < 4096; i++) img[i] = 8'hEE;
        b_n = 0;
    endtask

    task automatic do_xfer(input logic [31:0] a, input int n, input bit byp, input logic [7:0] seed);
        int start_done;
        int t;
        start_done = done_n;
        @(negedge clk);
        req_addr = a; req_len = LEN_W'(n); req_bypass = byp; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = seed + 8'(i);
            t = 0;
            while (!in_ready && t < 2000) begin
                @(negedge clk);
                t++;
            end
            chk(t < 2000, "R3", "byte accepted", 32'(i), 32'(n));
            @(negedge clk);
        end
        in_valid = 1'b0;
        t = 0;
        while (done_n == start_done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done_n == start_done + 1, "R9", "done pulse count", 32'(done_n - start_done), 1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R11", "req_ready", 32'(req_ready), 1);
        chk(in_ready == 1'b0, "R11", "in_ready", 32'(in_ready), 0);
        chk(mem_valid == 1'b0, "R11", "mem_valid", 32'(mem_valid), 0);
        chk(done == 1'b0, "R11", "done", 32'(done), 0);
    endtask

    task automatic t_swap_even();
        clear_log();
        do_xfer(32'h100, 10, 1'b0, 8'h30);
        chk(b_n == 1, "R4", "burst count", 32'(b_n), 1);
        chk(b_addr[0] == 32'h100, "R1", "addr", b_addr[0], 32'h100);
        chk(b_len[0] == 10, "R4", "len", 32'(b_len[0]), 10);
        for (int i = 0; i < 10; i++)
            chk(img[32'h100 + (i ^ 1)] == 8'h30 + 8'(i), "R4", "swapped byte",
                32'(img[32'h100 + (i ^ 1)]), 32'(8'h30 + 8'(i)));
    endtask

    task automatic t_swap_odd();
        clear_log();
        do_xfer(32'h201, 7, 1'b0, 8'h10);
        chk(b_n == 1, "R2", "burst count", 32'(b_n), 1);
        chk(b_addr[0] == 32'h200, "R2", "aligned addr", b_addr[0], 32'h200);
        chk(b_len[0] == 6, "R2", "even len", 32'(b_len[0]), 6);
        chk(img[32'h206] == 8'hEE, "R3", "dropped byte unwritten", 32'(img[32'h206]), 32'hEE);
        chk(img[32'h200] == 8'h11 && img[32'h201] == 8'h10, "R4", "pair swap",
            {img[32'h200], img[32'h201]}, 32'h1110);
    endtask

    task automatic t_bypass_odd();
        clear_log();
        do_xfer(32'h303, 5, 1'b1, 8'hA0);
        chk(b_n == 1 && b_addr[0] == 32'h303, "R5", "bypass addr", b_addr[0], 32'h303);
        chk(b_len[0] == 5, "R5", "bypass len", 32'(b_len[0]), 5);
        for (int i = 0; i < 5; i++)
            chk(img[32'h303 + i] == 8'hA0 + 8'(i), "R5", "bypass byte (R3 alignment)",
                32'(img[32'h303 + i]), 32'(8'hA0 + 8'(i)));
    endtask

    task automatic t_long_stall();
        clear_log();
        stall_en = 1'b1;
        hold_err = 0;
        overlap_err = 0;
        do_xfer(32'h400, 150, 1'b0, 8'h00);
        stall_en = 1'b0;
        chk(b_n == 3, "R6", "burst count", 32'(b_n), 3);
        chk(b_addr[0] == 32'h400 && b_len[0] == 64, "R6", "chunk0", b_addr[0], 32'h400);
        chk(b_addr[1] == 32'h440 && b_len[1] == 64, "R6", "chunk1", b_addr[1], 32'h440);
        chk(b_addr[2] == 32'h480 && b_len[2] == 22, "R6", "chunk2", 32'(b_len[2]), 22);
        for (int i = 0; i < 150; i++)
            chk(img[32'h400 + (i ^ 1)] == 8'(i), "R6", "data", 32'(img[32'h400 + (i ^ 1)]), 32'(8'(i)));
        chk(hold_err == 0, "R7", "burst dropped under stall", 32'(hold_err), 0);
        chk(overlap_err == 0, "R8", "in_ready during burst", 32'(overlap_err), 0);
    endtask

    task automatic t_base();
        clear_log();
        @(negedge clk);
        base_wr = 1'b1; base_wdata = 32'h8000_0300;
        @(negedge clk);
        base_wr = 1'b0;
        do_xfer(32'h0000_0041, 4, 1'b0, 8'h55);
        chk(b_addr[0] == 32'h8000_0340, "R12", "base or addr", b_addr[0], 32'h8000_0340);
        clear_log();
        do_xfer(32'h0000_0041, 3, 1'b1, 8'h66);
        chk(b_addr[0] == 32'h8000_0341, "R1", "base or bypass", b_addr[0], 32'h8000_0341);
        @(negedge clk);
        base_wr = 1'b1; base_wdata = '0;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic t_zero();
        clear_log();
        do_xfer(32'h500, 0, 1'b0, 8'h00);
        chk(b_n == 0, "R10", "no burst on zero", 32'(b_n), 0);
        do_xfer(32'h500, 1, 1'b0, 8'h77);
        chk(b_n == 0, "R10", "no burst on len one", 32'(b_n), 0);
        chk(img[32'h500] == 8'hEE, "R3", "single odd byte unwritten", 32'(img[32'h500]), 32'hEE);
        @(negedge clk);
        chk(in_ready == 1'b0 && req_ready == 1'b1, "R9", "idle after done",
            {in_ready, req_ready}, 32'b01);
        chk(done == 1'b0, "R9", "done single cycle", 32'(done), 0);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_swap_even();
                t_swap_odd();
                t_bypass_odd();
                t_long_stall();
                t_base();
                t_zero();
            end
            begin
                while (wd < 100000) begin
                    @(posedge clk);
                    wd++;
                end
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=<100000", wd);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule